// File: doc/BRIEF.md
# Processor Interrupt Cause and Mask Gating

This block is the processor-side stage that turns interrupt lines into one exception request. Six active-low hardware lines are brought into the clock domain through a two-stage synchronizer. Line 3 of these is the summary line from the on-chip interrupt aggregator. A timer interrupt, gated by an enable fixed at reset, is combined with them, and two software interrupt bits complete an eight-bit cause field. Each cause bit is qualified by its own bit in a status mask. The surviving bits are ORed together, and the result is further gated by a global enable to form the exception request.

External line 5 and the enabled timer share the top cause bit. A separate source register shows line 5 on its own, so a handler can tell which of the two raised the bit. Software reaches the block through a small word-wide register port. The port reads the cause field, writes the software bits, reads and writes the mask and global enable, and reads the source flag.

Top module: `irq_cause_gate`

## Requirements
- R1: After reset, the cause field, software bits, mask and global enable all read zero, and `exc_req` is low.
- R2: A hardware line held low is reflected in its cause bit after exactly two rising clock edges, and not after one. Cause bits 14, 13, 12, 11 and 10 (data bits of address 0) follow lines 4, 3, 2, 1 and 0.
- R3: Cause bit 15 is high when line 5 is low, or when `timer_irq` is high and the timer enable is set.
- R4: A write to address 0 replaces software bits 9:8 with write data bits 9:8. Write data bits 15:10 have no effect on the cause field.
- R5: Address 1 holds the mask in bits 15:8 and the global enable in bit 0, both read/write. Bit 2 reads the timer enable, and writes to bit 2 have no effect. All other bits read zero.
- R6: `exc_req` is high exactly when the global enable is set and at least one cause bit has its mask bit set.
- R7: Address 2 bit 0 reads the synchronized state of line 5 alone, unaffected by the timer. Its other bits read zero, and so does every bit of address 3.
- R8: The timer enable takes the value of `tmr_en_cfg` while reset is asserted. Changes of that input after reset have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hw_irq_n | input | 6 | Active-low hardware interrupt lines 0..5 (line 3 from the aggregator) |
| timer_irq | input | 1 | Active-high timer interrupt |
| tmr_en_cfg | input | 1 | Timer enable value, captured during reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 cause, 1 status, 2 source |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| exc_req | output | 1 | Exception request |

## Verification
Two functions can land on the same bit in the same cycle. These are the timer path and external line 5, which both drive cause bit 15. The bench raises the timer alone, line 5 alone, and both together. In each case it judges cause bit 15 and the separate source flag, and the flag must rise only when line 5 is present. A second such meeting happens at the request gate. A masked-in software bit and a cleared global enable are applied together, and `exc_req` must stay low.

// File: rtl/irqg_pkg.sv
package irqg_pkg;
   localparam int RA_W = 2;

   typedef enum logic [RA_W-1:0] {
      RA_CAUSE  = 2'd0,
      RA_STATUS = 2'd1,
      RA_SOURCE = 2'd2,
      RA_SPARE  = 2'd3
   } ra_e;

   localparam int ST_GIE_BIT  = 0;
   localparam int ST_TEN_BIT  = 2;
   localparam int SRC_EXT_BIT = 0;
endpackage

// File: rtl/irqg_sync.sv
module irqg_sync #(
   parameter int W      = 7,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("irqg_sync: STAGES must be at least 2");
   end
   if (W < 1) begin : g_bad_width
      $error("irqg_sync: W must be positive");
   end

   logic [W-1:0] st [STAGES];

   for (genvar k = 0; k < STAGES; k++) begin : g_stage
      if (k == 0) begin : g_first
         always_ff @(posedge clk) begin
            if (!rst_n) st[k] <= '0;
            else        st[k] <= d;
         end
      end else begin : g_rest
         always_ff @(posedge clk) begin
            if (!rst_n) st[k] <= '0;
            else        st[k] <= st[k-1];
         end
         // R2
         stage_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) |-> st[k] == $past(st[k-1]));
      end
   end

   assign q = st[STAGES-1];
endmodule

// File: rtl/irqg_regs.sv
module irqg_regs
   import irqg_pkg::*;
#(
   parameter int CAUSE_W = 8,
   parameter int SW_W    = 2,
   parameter int DATA_W  = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tmr_en_cfg,
   input  logic               wr,
   input  logic [RA_W-1:0]    addr,
   input  logic [DATA_W-1:0]  wdata,
   input  logic [CAUSE_W-1:0] cause,
   input  logic               ext_flag,
   output logic [SW_W-1:0]    sw,
   output logic [CAUSE_W-1:0] mask,
   output logic               gie,
   output logic               tmr_en,
   output logic [DATA_W-1:0]  rdata
);
   localparam int CAUSE_LSB = DATA_W - CAUSE_W;

   if (CAUSE_LSB <= ST_TEN_BIT) begin : g_bad_layout
      $error("irqg_regs: DATA_W too small for cause and status fields");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sw     <= '0;
         mask   <= '0;
         gie    <= 1'b0;
         tmr_en <= tmr_en_cfg;
      end else if (wr) begin
         if (ra_e'(addr) == RA_CAUSE)
            sw <= wdata[CAUSE_LSB +: SW_W];
         if (ra_e'(addr) == RA_STATUS) begin
            mask <= wdata[CAUSE_LSB +: CAUSE_W];
            gie  <= wdata[ST_GIE_BIT];
         end
      end
   end

   always_comb begin
      rdata = '0;
      unique case (ra_e'(addr))
         RA_CAUSE:  rdata[CAUSE_LSB +: CAUSE_W] = cause;
         RA_STATUS: begin
            rdata[CAUSE_LSB +: CAUSE_W] = mask;
            rdata[ST_GIE_BIT]           = gie;
            rdata[ST_TEN_BIT]           = tmr_en;
         end
         RA_SOURCE: rdata[SRC_EXT_BIT] = ext_flag;
         RA_SPARE:  rdata = '0;
      endcase
   end

   // R4
   sw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr && ra_e'(addr) == RA_CAUSE) |=> $stable(sw));
   // R5
   mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr && ra_e'(addr) == RA_STATUS) |=> $stable(mask) && $stable(gie));
   // R8
   tmr_en_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> $stable(tmr_en));
endmodule

// File: rtl/irq_cause_gate.sv
module irq_cause_gate
   import irqg_pkg::*;
#(
   parameter int N_HW        = 6,
   parameter int SW_W        = 2,
   parameter int SYNC_STAGES = 2,
   parameter int DATA_W      = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_HW-1:0]   hw_irq_n,
   input  logic              timer_irq,
   input  logic              tmr_en_cfg,
   input  logic              reg_wr,
   input  logic [RA_W-1:0]   reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              exc_req
);
   localparam int CAUSE_W = N_HW + SW_W;
   localparam int SYNC_W  = N_HW + 1;

   if (N_HW < 2) begin : g_bad_hw
      $error("irq_cause_gate: N_HW must be at least 2");
   end
   if (CAUSE_W > DATA_W) begin : g_bad_data
      $error("irq_cause_gate: cause field wider than data word");
   end

   logic [SYNC_W-1:0]  raw_act;
   logic [SYNC_W-1:0]  sync_act;
   logic [N_HW-1:0]    hw_s;
   logic               tmr_s;
   logic [SW_W-1:0]    sw;
   logic [CAUSE_W-1:0] mask;
   logic               gie;
   logic               tmr_en;
   logic [CAUSE_W-1:0] cause;
   logic               ext_flag;

   assign raw_act = {timer_irq, ~hw_irq_n};

   irqg_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (raw_act),
      .q     (sync_act)
   );

   assign hw_s     = sync_act[N_HW-1:0];
   assign tmr_s    = sync_act[N_HW];
   assign ext_flag = hw_s[N_HW-1];
   assign cause    = {hw_s[N_HW-1] | (tmr_s & tmr_en), hw_s[N_HW-2:0], sw};
   assign exc_req  = gie & |(cause & mask);

   irqg_regs #(.CAUSE_W(CAUSE_W), .SW_W(SW_W), .DATA_W(DATA_W)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .tmr_en_cfg (tmr_en_cfg),
      .wr         (reg_wr),
      .addr       (reg_addr),
      .wdata      (reg_wdata),
      .cause      (cause),
      .ext_flag   (ext_flag),
      .sw         (sw),
      .mask       (mask),
      .gie        (gie),
      .tmr_en     (tmr_en),
      .rdata      (reg_rdata)
   );

   // R6
   req_gie_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !gie |-> !exc_req);
   // R6
   req_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      exc_req |-> (cause & mask) != '0);
   // R7
   ext_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ext_flag |-> cause[CAUSE_W-1]);
   // R3
   timer_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!tmr_en && !ext_flag) |-> !cause[CAUSE_W-1]);
endmodule

// File: tb/irq_cause_gate_bench.sv
module irq_cause_gate_bench;
   typedef struct packed {
      logic [5:0] irqn;
      logic       tmr;
      logic [7:0] mask;
      logic       gie;
      logic [1:0] sw;
      logic [7:0] ecause;
      logic       ereq;
      logic       eflag;
   } vec_t;

   localparam int NV = 10;
   localparam vec_t VEC [NV] = '{
      '{6'h3F, 1'b0, 8'hFF, 1'b1, 2'b00, 8'h00, 1'b0, 1'b0},
      '{6'h3E, 1'b0, 8'hFF, 1'b1, 2'b00, 8'h04, 1'b1, 1'b0},
      '{6'h3E, 1'b0, 8'hFB, 1'b1, 2'b00, 8'h04, 1'b0, 1'b0},
      '{6'h3F, 1'b1, 8'h80, 1'b1, 2'b00, 8'h80, 1'b1, 1'b0},
      '{6'h1F, 1'b0, 8'h80, 1'b1, 2'b00, 8'h80, 1'b1, 1'b1},
      '{6'h3F, 1'b0, 8'h01, 1'b1, 2'b01, 8'h01, 1'b1, 1'b0},
      '{6'h3F, 1'b0, 8'h02, 1'b0, 2'b11, 8'h03, 1'b0, 1'b0},
      '{6'h37, 1'b0, 8'h20, 1'b1, 2'b00, 8'h20, 1'b1, 1'b0},
      '{6'h00, 1'b1, 8'h00, 1'b1, 2'b10, 8'hFE, 1'b0, 1'b1},
      '{6'h00, 1'b0, 8'h40, 1'b1, 2'b00, 8'hFC, 1'b1, 1'b1}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [5:0]  hw_irq_n = 6'h3F;
   logic        timer_irq = 1'b0;
   logic        tmr_en_cfg = 1'b1;
   logic        reg_wr = 1'b0;
   logic [1:0]  reg_addr = 2'd0;
   logic [15:0] reg_wdata = 16'h0;
   logic [15:0] reg_rdata;
   logic        exc_req;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   irq_cause_gate u_irq_cause_gate (
      .clk        (clk),
      .rst_n      (rst_n),
      .hw_irq_n   (hw_irq_n),
      .timer_irq  (timer_irq),
      .tmr_en_cfg (tmr_en_cfg),
      .reg_wr     (reg_wr),
      .reg_addr   (reg_addr),
      .reg_wdata  (reg_wdata),
      .reg_rdata  (reg_rdata),
      .exc_req    (exc_req)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [15:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [15:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic do_reset(input logic cfg);
      @(negedge clk);
      rst_n = 1'b0; tmr_en_cfg = cfg;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic settle();
      repeat (2) @(posedge clk);
   endtask

   initial begin
      logic [15:0] d;
      do_reset(1'b1);
      // R1 reset state
      rd(2'd0, d); chk("R1 cause", d, 16'h0000);
      rd(2'd1, d); chk("R1 status", d, 16'h0004);
      chk("R1 exc_req", exc_req, 1'b0);

      // table walk: R2 R3 R5 R6 R7
      for (int i = 0; i < NV; i++) begin
         wr(2'd1, {VEC[i].mask, 8'h00} | {15'h0, VEC[i].gie});
         wr(2'd0, {6'h00, VEC[i].sw, 8'h00});
         @(negedge clk);
         hw_irq_n = VEC[i].irqn; timer_irq = VEC[i].tmr;
         settle();
         rd(2'd0, d); chk("R2/R3 cause", d, {VEC[i].ecause, 8'h00});
         chk("R6 exc_req", exc_req, VEC[i].ereq);
         rd(2'd2, d); chk("R7 source", d, {15'h0, VEC[i].eflag});
      end

      // R2 latency: one edge not enough, two edges enough
      @(negedge clk);
      hw_irq_n = 6'h3F; timer_irq = 1'b0;
      wr(2'd0, 16'h0000);
      settle();
      @(negedge clk);
      reg_addr = 2'd0;
      hw_irq_n = 6'h2F;
      @(posedge clk); @(negedge clk); #1;
      chk("R2 one edge", reg_rdata, 16'h0000);
      @(posedge clk); @(negedge clk); #1;
      chk("R2 two edges", reg_rdata, 16'h4000);
      hw_irq_n = 6'h3F;
      settle();

      // R4 writes to hardware cause bits ignored
      wr(2'd0, 16'hFE00);
      rd(2'd0, d); chk("R4 hw bits ignored", d, 16'h0200);
      wr(2'd0, 16'h0000);
      rd(2'd0, d); chk("R4 sw clear", d, 16'h0000);

      // R7 spare address reads zero
      rd(2'd3, d); chk("R7 spare", d, 16'h0000);

      // R8 / R5: reset with timer disabled, then raise cfg
      do_reset(1'b0);
      @(negedge clk); tmr_en_cfg = 1'b1;
      wr(2'd1, 16'hFFFF);
      rd(2'd1, d); chk("R5 tmr bit read-only", d, 16'hFF01);
      @(negedge clk); timer_irq = 1'b1;
      settle();
      rd(2'd0, d); chk("R8 timer stays disabled", d, 16'h0000);
      chk("R8 no request", exc_req, 1'b0);
      rd(2'd2, d); chk("R7 timer not flagged", d, 16'h0000);

      // R6 global enable off with masked-in sw bit
      wr(2'd1, 16'hFF00);
      wr(2'd0, 16'h0100);
      @(negedge clk);
      chk("R6 gie off", exc_req, 1'b0);
      wr(2'd1, 16'hFF01);
      @(negedge clk);
      chk("R6 gie on", exc_req, 1'b1);

      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      #(20 * 100000);
      if (!done) begin
         done = 1'b1;
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule